// File: doc/BRIEF.md
# SPI Slave Receiver with Overrun Detection

This block is the target side of a four-wire serial link. It samples an external serial clock, a select and a data-in line with the system clock. It shifts words of 8 to 16 bits in and out, most significant bit first, in any of the four clock polarity and phase combinations. Each word that completes is handed to a receive data register, and a full flag is raised. If the previous word has not been collected yet, the new word is dropped and an overrun flag is raised instead. A rising edge on the select line is also recorded as a flag.

Software reaches the block through a plain strobe interface: write strobe, read strobe, address and data. The data shifted out is whatever the shift register holds when a transfer begins. That is either a word written to the transmit address while the block is deselected, or the word received last. Three interrupt enable bits are set and cleared through two separate write-only addresses. The interrupt output is high when any flag is set together with its enable bit.

Top module: `spi_slave_rx`

## Requirements
- R1: After reset the status, the enable mask and the configuration read as zero, and `irq_o` is low.
- R2: The word length is 8 plus the length field (configuration bits 7:4). Field values above 8 give 16 bits. The received word sits in the low bits of the data register (address 1), and the bits above the length read as zero.
- R3: Configuration bit 0 selects the phase and bit 1 the idle clock level. With phase 0, data is sampled on the edge leaving idle and driven on the edge returning to idle. With phase 1, it is driven on the edge leaving idle and sampled on the edge returning to idle.
- R4: When a word completes while status bit 0 (full) is clear, the word is written to the data register and status bit 0 is set.
- R5: When a word completes while status bit 0 is set, the data register keeps its value and status bit 1 (overrun) is set.
- R6: A read of address 1 clears status bit 0. A read of the status register (address 3) clears status bits 1 and 2.
- R7: The first bit driven in a transfer is bit length-1 of the shift register contents at the start. A write to address 2 loads the shift register only while the select is high. Such a write while selected has no effect.
- R8: Without a new write to address 2, the next transfer shifts out the previously received word.
- R9: A rising edge of the select sets status bit 2.
- R10: A write to address 4 sets the enable bits where the data has ones. A write to address 5 clears them where the data has ones. Zero bits leave an enable unchanged. The enable mask reads at address 6, and writes to address 6 have no effect.
- R11: `irq_o` equals the OR over the three status bits, each ANDed with its enable bit.
- R12: Clock edges while the select is high are ignored. A deselect in the middle of a word discards the partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | External serial clock |
| sel_n_i | input | 1 | External select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reads with side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the current address |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit count or a wrong sampling edge shows up as a wrong data register value on the first read after the transfer. A wrong driving edge shows as a corrupted word captured from `miso_o` in the same transfer. A wrong full or overrun state changes `irq_o` three system clocks after the last sampling edge, and the bench compares `irq_o` every cycle, so a flag that is set or cleared at the wrong time is reported within one cycle. A wrong enable bit appears at address 6 and on `irq_o` on the cycle after the write.

// File: rtl/spi_slave_rx.sv
module spi_slave_rx #(
  parameter int unsigned MIN_BITS = 8,
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned AW       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                sel_n_i,
  input  logic                mosi_i,
  output logic                miso_o,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [AW-1:0]       reg_addr,
  input  logic [MAX_BITS-1:0] reg_wdata,
  output logic [MAX_BITS-1:0] reg_rdata,
  output logic                irq_o
);
  localparam int unsigned IW = $clog2(MAX_BITS);
  localparam int unsigned CW = $clog2(MAX_BITS + 1);
  localparam logic [AW-1:0] A_CFG  = AW'(0);
  localparam logic [AW-1:0] A_RXD  = AW'(1);
  localparam logic [AW-1:0] A_TXD  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam logic [AW-1:0] A_IDIS = AW'(5);
  localparam logic [AW-1:0] A_MASK = AW'(6);

  logic [2:0] sck_p, sel_p;
  logic [1:0] mosi_p;
  logic [1:0] mode_q;
  logic [3:0] lenf_q;
  logic [MAX_BITS-1:0] sh_q, rxd_q;
  logic [CW-1:0] cnt_q;
  logic full_q, ovr_q, selr_q, miso_q;
  logic [2:0] mask_q;

  wire cpha = mode_q[0];
  wire cpol = mode_q[1];

  logic [CW-1:0] len;
  assign len = (lenf_q > 4'(MAX_BITS - MIN_BITS)) ? CW'(MAX_BITS) : CW'(MIN_BITS) + CW'(lenf_q);
  wire [IW-1:0] msb = IW'(len - CW'(1));

  wire active   = ~sel_p[1];
  wire sel_fall = ~sel_p[1] & sel_p[2];
  wire sel_rise = sel_p[1] & ~sel_p[2];
  wire sck_edge = sck_p[1] ^ sck_p[2];
  wire lead     = sck_p[1] != cpol;
  wire smp      = active & sck_edge & (lead ^ cpha);
  wire drv      = active & sck_edge & ~(lead ^ cpha);
  wire word_done = smp && (cnt_q == len - CW'(1));

  wire [MAX_BITS-1:0] sh_nx = {sh_q[MAX_BITS-2:0], mosi_p[1]};
  wire [MAX_BITS-1:0] wmask = ~({MAX_BITS{1'b1}} << len);

  wire wr_cfg  = reg_wr && reg_addr == A_CFG;
  wire wr_txd  = reg_wr && reg_addr == A_TXD;
  wire wr_ien  = reg_wr && reg_addr == A_IEN;
  wire wr_idis = reg_wr && reg_addr == A_IDIS;
  wire rd_rxd  = reg_rd && reg_addr == A_RXD;
  wire rd_stat = reg_rd && reg_addr == A_STAT;

  wire [2:0] status = {selr_q, ovr_q, full_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= '0;
      sel_p  <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck_i};
      sel_p  <= {sel_p[1:0], sel_n_i};
      mosi_p <= {mosi_p[0], mosi_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      if (!active)  cnt_q <= '0;
      else if (smp) cnt_q <= word_done ? '0 : cnt_q + CW'(1);
      if (smp)                    sh_q <= sh_nx;
      else if (wr_txd && !active) sh_q <= reg_wdata;
      if ((sel_fall && !cpha) || drv) miso_q <= sh_q[msb];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      selr_q <= 1'b0;
      rxd_q  <= '0;
    end else begin
      if (rd_rxd) full_q <= 1'b0;
      if (rd_stat) begin
        ovr_q  <= 1'b0;
        selr_q <= 1'b0;
      end
      if (word_done) begin
        if (full_q) ovr_q <= 1'b1;
        else begin
          full_q <= 1'b1;
          rxd_q  <= sh_nx & wmask;
        end
      end
      if (sel_rise) selr_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      lenf_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg) begin
        mode_q <= reg_wdata[1:0];
        lenf_q <= reg_wdata[7:4];
      end
      if (wr_ien)       mask_q <= mask_q | reg_wdata[2:0];
      else if (wr_idis) mask_q <= mask_q & ~reg_wdata[2:0];
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:   reg_rdata[7:0] = {lenf_q, 2'b00, mode_q};
      A_RXD:   reg_rdata = rxd_q;
      A_STAT:  reg_rdata[2:0] = status;
      A_MASK:  reg_rdata[2:0] = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assign miso_o = miso_q;
  assign irq_o  = |(status & mask_q);
endmodule

// File: rtl/spi_slave_rx_chk.sv
module spi_slave_rx_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          irq_o,
  input logic          full,
  input logic          ovr,
  input logic          selr,
  input logic [DW-1:0] rxd,
  input logic [2:0]    mask,
  input logic          word_done,
  input logic          sel_dly
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_DATA_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$stable(rxd) |-> !$past(full)); // R4
  AST_FULL_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(full) |-> $past(word_done)); // R4
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(ovr) |-> $stable(rxd)); // R5
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (reg_rd && reg_addr == AW'(1) && !word_done) |=> !full); // R6
  AST_SELRISE_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(selr) |-> sel_dly); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (reg_wr && reg_addr == AW'(4)) |=> ((mask & $past(reg_wdata[2:0])) == $past(reg_wdata[2:0]))); // R10
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (reg_wr && reg_addr == AW'(5)) |=> ((mask & $past(reg_wdata[2:0])) == 3'b000)); // R10
  AST_IRQ_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (mask == 3'b000) |-> !irq_o); // R11
endmodule

bind spi_slave_rx spi_slave_rx_chk #(.AW(AW), .DW(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .full(full_q), .ovr(ovr_q), .selr(selr_q),
  .rxd(rxd_q), .mask(mask_q), .word_done(word_done), .sel_dly(sel_p[2])
);

// File: tb/tb_spi_slave_rx.sv
module tb_spi_slave_rx;
  logic clk = 0, rst_n = 0, sck = 0, sel_n = 1, mosi = 0, wr = 0, rd = 0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic miso, irq;

  spi_slave_rx dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n), .mosi_i(mosi), .miso_o(miso),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  int vectors = 0, errs = 0, cyc = 0;
  bit finished = 0;

  localparam int EV_WORD = 0, EV_SELR = 1, EV_RDD = 2, EV_RDS = 3, EV_MSET = 4, EV_MCLR = 5;
  typedef struct { int t; int kind; logic [15:0] d; } ev_t;
  ev_t evq[$];
  bit m_full = 0, m_ovr = 0, m_selr = 0;
  logic [15:0] m_rxd = '0;
  logic [2:0] m_mask = '0;

  task automatic push(int dly, int kind, logic [15:0] d);
    ev_t e;
    e.t = cyc + dly; e.kind = kind; e.d = d;
    evq.push_back(e);
  endtask

  always @(posedge clk) begin
    int i;
    cyc++;
    i = 0;
    while (i < evq.size()) begin
      if (evq[i].t == cyc) begin
        case (evq[i].kind)
          EV_WORD: if (m_full) m_ovr = 1; else begin m_rxd = evq[i].d; m_full = 1; end
          EV_SELR: m_selr = 1;
          EV_RDD:  m_full = 0;
          EV_RDS:  begin m_ovr = 0; m_selr = 0; end
          EV_MSET: m_mask = m_mask | evq[i].d[2:0];
          EV_MCLR: m_mask = m_mask & ~evq[i].d[2:0];
          default: ;
        endcase
        evq.delete(i);
      end else i++;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !finished) chk("R11 irq per-cycle", 32'(irq), 32'(|({m_selr, m_ovr, m_full} & m_mask)));

  task automatic wreg(logic [2:0] a, logic [15:0] d);
    wr = 1; addr = a; wdata = d;
    if (a == 3'd4) push(1, EV_MSET, d);
    if (a == 3'd5) push(1, EV_MCLR, d);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rchk(logic [2:0] a, logic [15:0] exp, string r);
    rd = 1; addr = a;
    #1;
    chk(r, 32'(rdata), 32'(exp));
    if (a == 3'd1) push(1, EV_RDD, 0);
    if (a == 3'd3) push(1, EV_RDS, 0);
    @(negedge clk);
    rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(logic [1:0] mode, int n, logic [15:0] din, int k, output logic [15:0] dout);
    logic cpha = mode[0], cpol = mode[1];
    logic [15:0] m = 16'((32'd1 << n) - 1);
    dout = '0;
    sck = cpol; idle(6);
    if (!cpha) mosi = din[n-1];
    sel_n = 0; idle(8);
    for (int i = n - 1; i >= n - k; i--) begin
      if (!cpha) begin
        dout[i] = miso; sck = ~cpol;
        if (i == 0) push(3, EV_WORD, din & m);
        idle(8);
        sck = cpol;
        if (i > 0) mosi = din[i-1];
        idle(8);
      end else begin
        sck = ~cpol; mosi = din[i]; idle(8);
        dout[i] = miso; sck = cpol;
        if (i == 0) push(3, EV_WORD, din & m);
        idle(8);
      end
    end
    sel_n = 1; push(3, EV_SELR, 0); idle(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    idle(5);
    rst_n = 1;
    idle(2);
    rchk(3'd3, 16'h0000, "R1 status");
    rchk(3'd6, 16'h0000, "R1 mask");
    rchk(3'd0, 16'h0000, "R1 config");
    chk("R1 irq", 32'(irq), 0);

    wreg(3'd4, 16'h0007); rchk(3'd6, 16'h0007, "R10 enable set");
    wreg(3'd4, 16'h0000); rchk(3'd6, 16'h0007, "R10 zero write to enable");
    wreg(3'd6, 16'h0000); rchk(3'd6, 16'h0007, "R10 mask read-only");
    wreg(3'd5, 16'h0002); rchk(3'd6, 16'h0005, "R10 disable clear");
    wreg(3'd5, 16'h0000); rchk(3'd6, 16'h0005, "R10 zero write to disable");
    wreg(3'd4, 16'h0002); rchk(3'd6, 16'h0007, "R10 enable again");

    wreg(3'd0, 16'h0000); wreg(3'd2, 16'h00A5);
    xfer(2'd0, 8, 16'h003C, 8, d);
    chk("R7 first word out mode0", 32'(d), 32'h00A5);
    rchk(3'd3, 16'h0005, "R4 full and R9 select rise");
    rchk(3'd1, 16'h003C, "R4 data");
    rchk(3'd3, 16'h0000, "R6 flags cleared");

    xfer(2'd0, 8, 16'h005A, 8, d);
    chk("R8 echo of last word", 32'(d), 32'h003C);
    rchk(3'd1, 16'h005A, "R4 second word");
    rchk(3'd3, 16'h0004, "R6 data read cleared full");
    rchk(3'd3, 16'h0000, "R6 status read cleared rise");

    wreg(3'd0, 16'h0081); wreg(3'd2, 16'hBEEF);
    xfer(2'd1, 16, 16'h1234, 16, d);
    chk("R3 mode1 16-bit out", 32'(d), 32'hBEEF);
    rchk(3'd1, 16'h1234, "R2 16-bit word");
    rchk(3'd3, 16'h0004, "R6 status");

    wreg(3'd0, 16'h0042); wreg(3'd2, 16'hFABC);
    xfer(2'd2, 12, 16'h05A5, 12, d);
    chk("R3 mode2 12-bit out", 32'(d), 32'h0ABC);
    rchk(3'd1, 16'h05A5, "R2 12-bit word upper zero");
    rchk(3'd3, 16'h0004, "R6 status");

    wreg(3'd0, 16'h00F3); wreg(3'd2, 16'hC3A5);
    xfer(2'd3, 16, 16'h8001, 16, d);
    chk("R3 mode3 out", 32'(d), 32'hC3A5);
    rchk(3'd1, 16'h8001, "R2 length field above 8");
    rchk(3'd3, 16'h0004, "R6 status");

    wreg(3'd0, 16'h0000);
    xfer(2'd0, 8, 16'h0011, 8, d);
    xfer(2'd0, 8, 16'h0022, 8, d);
    rchk(3'd3, 16'h0007, "R5 overrun flag");
    rchk(3'd1, 16'h0011, "R5 first word kept");
    rchk(3'd3, 16'h0000, "R6 overrun cleared");

    sck = 1; idle(6); sck = 0; idle(6); sck = 1; idle(6); sck = 0; idle(6);
    rchk(3'd3, 16'h0000, "R12 clock ignored while deselected");
    xfer(2'd0, 8, 16'h00FF, 3, d);
    rchk(3'd3, 16'h0004, "R12 partial word discarded");
    xfer(2'd0, 8, 16'h0069, 8, d);
    rchk(3'd1, 16'h0069, "R12 clean word after partial");
    rchk(3'd3, 16'h0004, "R6 status");

    wreg(3'd2, 16'h00C6);
    sel_n = 0; idle(8);
    wreg(3'd2, 16'h0000);
    idle(4);
    sel_n = 1; push(3, EV_SELR, 0); idle(8);
    xfer(2'd0, 8, 16'h0000, 8, d);
    chk("R7 write while selected ignored", 32'(d), 32'h00C6);
    rchk(3'd1, 16'h0000, "R4 zero word");
    rchk(3'd3, 16'h0004, "R6 status");

    xfer(2'd0, 8, 16'h0077, 8, d);
    wreg(3'd5, 16'h0007);
    chk("R11 irq low with mask clear", 32'(irq), 0);
    wreg(3'd4, 16'h0001);
    chk("R11 irq from full", 32'(irq), 1);
    rchk(3'd6, 16'h0001, "R10 mask");
    rchk(3'd1, 16'h0077, "R4 data");
    chk("R11 irq drops after read", 32'(irq), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule